// File: doc/BRIEF.md
# Multimode Timer Waveform Generator

A 16-bit timer that counts either in one direction (wrapping back to zero) or up and down between zero and a TOP value. Two compare channels, A and B, each watch the count and drive one waveform pin. A single 4-bit mode code chooses both how the counter moves and where its TOP value comes from. TOP can be a fixed value, the active value of compare channel A, or a separate TOP register (the capture register). The mode code also decides what each channel's 2-bit output code means. The counter only moves on cycles where an external prescaler raises the `tick` input.

The block is programmed through a simple write-only port: a write enable, a 3-bit address and a data word. Software can:
- write the counter;
- write both compare values and the TOP register;
- fire one-cycle force strobes;
- clear the compare-match and overflow flags by writing ones.

In the PWM modes the compare values pass through a buffer and only take effect at the point of the period that the mode defines. This keeps the waveforms glitch-free.

Top module: `wave_timer`

## Requirements
- R1: After a synchronous reset, the count is 0, both pins are 0, all three flags are 0, the mode is 0 and both output codes are 00.
- R2: The counter moves only on cycles with `tick` high. A counter write loads the data, and in that cycle there is no count step and no compare match.
- R3: In normal mode (0) and clear-on-compare modes (4: TOP = compare A, 12: TOP = TOP register), each tick adds one. A tick at TOP or at 0xFFFF makes the next count 0 and sets the overflow flag. Mode 0 has TOP 0xFFFF.
- R4: Modes 1/2/3 (phase-correct) and 5/6/7 (fast PWM) use fixed TOP 0x00FF, 0x01FF and 0x03FF, chosen by mode bits [1:0] = 1, 2, 3.
- R5: Dual-slope modes are 1–3 and 10/11 (phase-correct) and 8/9 (phase-and-frequency-correct). They count up to TOP and then down to 0, turning at each end. A tick at or above TOP while counting up turns the counter down and decrements it. A tick at 0 while counting down turns it up to 1. The overflow flag is set when a step down reaches 0. Writing the control register restarts the direction as up. Modes 8/10 take TOP from the TOP register; modes 9/11 take TOP from compare A.
- R6: In modes 0, 4 and 12, a match (tick, no counter write, count equal to the active compare value) sets that channel's flag. The output code then acts as follows: 00 drives the pin 0, 01 toggles, 10 clears, 11 sets.
- R7: Fast PWM modes are 5–7, 14 (TOP register) and 15 (compare A). Code 10 clears on match and sets at the wrap to BOTTOM. Code 11 sets on match and clears at the wrap. When both happen on the same tick, the wrap action wins.
- R8: In dual-slope modes, code 10 clears on a match while counting up and sets on a match while counting down. Code 11 does the opposite.
- R9: In the PWM modes, code 01 toggles pin A on match only in modes 9, 11, 14 and 15. In every other case of code 01 in a PWM mode, the pin is driven 0.
- R10: A force strobe applies the channel's output-code action at once, but only in modes 0, 4 and 12. It sets no flag and never resets the counter. In PWM modes it changes nothing.
- R11: In modes 0, 4 and 12 a compare write takes effect at once. In PWM modes the write goes to a buffer, which becomes active at a fixed point:
  - fast PWM: at the wrap tick;
  - phase-correct: at the turn at TOP;
  - phase-and-frequency-correct: at the turn at 0.
- R12: Writing 1 to a flag-clear bit clears that flag. A flag set in the same cycle wins over the clear.
- R13: Mode 13 is reserved. In this mode the counter holds its value and both pins are driven 0.
- R14: Write address map:
  - 0: control (bits [3:0] mode, [5:4] code A, [7:6] code B);
  - 1: compare A;
  - 2: compare B;
  - 3: TOP register;
  - 4: counter;
  - 5: force strobes (bit 0 = A, bit 1 = B);
  - 6: flag clear (bit 0 = A, bit 1 = B, bit 2 = overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from external prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register address |
| wr_data | input | CW (16) | Write data |
| count_o | output | CW (16) | Current counter value |
| wave_a_o | output | 1 | Channel A waveform pin |
| wave_b_o | output | 1 | Channel B waveform pin |
| flag_a_o | output | 1 | Channel A compare-match flag |
| flag_b_o | output | 1 | Channel B compare-match flag |
| flag_ovf_o | output | 1 | Overflow flag |

## Verification
The hardest situations to reach from the ports are the ones where a compare event lands on the same tick as a period boundary. Examples are a match that coincides with the fast-PWM wrap, a buffered compare write that lands just before the update point, and a flag clear in the same cycle as a new match. The stimulus sets compare B equal to TOP in fast PWM, rewrites compare values in the middle of a period in each PWM family, and repeats flag-clear writes every other cycle while matches recur. These cases line up without hand timing, and a behavioural model compares every output on every clock.

// File: rtl/wtimer_pkg.sv
package wtimer_pkg;
  typedef enum logic [2:0] {FAM_NORM, FAM_CTC, FAM_FAST, FAM_PC, FAM_PFC, FAM_RSV} fam_e;
  typedef enum logic [1:0] {TOPS_FIXED, TOPS_CMPA, TOPS_CAP} topsel_e;

  typedef struct packed {
    fam_e       fam;
    topsel_e    tsel;
    logic [1:0] fixw;   // 0: full range, 1..3: 8/9/10-bit
    logic       tog_a;  // code 01 toggles channel A in PWM
  } mode_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CMPA  = 3'd1;
  localparam logic [2:0] A_CMPB  = 3'd2;
  localparam logic [2:0] A_TOPR  = 3'd3;
  localparam logic [2:0] A_CNT   = 3'd4;
  localparam logic [2:0] A_FORCE = 3'd5;
  localparam logic [2:0] A_CLR   = 3'd6;

  function automatic mode_t decode_mode(input logic [3:0] m);
    mode_t d;
    d = '{fam: FAM_NORM, tsel: TOPS_FIXED, fixw: 2'd0, tog_a: 1'b0};
    case (m)
      4'd0:               ;
      4'd1, 4'd2, 4'd3:   begin d.fam = FAM_PC;   d.fixw = m[1:0]; end
      4'd4:               begin d.fam = FAM_CTC;  d.tsel = TOPS_CMPA; end
      4'd5, 4'd6, 4'd7:   begin d.fam = FAM_FAST; d.fixw = m[1:0]; end
      4'd8:               begin d.fam = FAM_PFC;  d.tsel = TOPS_CAP; end
      4'd9:               begin d.fam = FAM_PFC;  d.tsel = TOPS_CMPA; d.tog_a = 1'b1; end
      4'd10:              begin d.fam = FAM_PC;   d.tsel = TOPS_CAP; end
      4'd11:              begin d.fam = FAM_PC;   d.tsel = TOPS_CMPA; d.tog_a = 1'b1; end
      4'd12:              begin d.fam = FAM_CTC;  d.tsel = TOPS_CAP; end
      4'd13:              d.fam = FAM_RSV;
      4'd14:              begin d.fam = FAM_FAST; d.tsel = TOPS_CAP;  d.tog_a = 1'b1; end
      default:            begin d.fam = FAM_FAST; d.tsel = TOPS_CMPA; d.tog_a = 1'b1; end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/wt_counter.sv
module wt_counter
  import wtimer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  fam_e          fam_i,
  input  logic [CW-1:0] top_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dir_rst_i,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          adv_o,
  output logic          wrap_evt_o,
  output logic          top_evt_o,
  output logic          bot_evt_o,
  output logic          ovf_evt_o
);
  localparam logic [CW-1:0] MAXV = '1;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic single, dual;

  always_comb begin
    single     = (fam_i == FAM_NORM) || (fam_i == FAM_CTC) || (fam_i == FAM_FAST);
    dual       = (fam_i == FAM_PC) || (fam_i == FAM_PFC);
    adv_o      = tick_i && !load_i && (fam_i != FAM_RSV);
    wrap_evt_o = adv_o && single && ((cnt_o == top_i) || (cnt_o == MAXV));
    top_evt_o  = adv_o && dual && up_o && (cnt_o >= top_i);
    bot_evt_o  = adv_o && dual && !up_o && (cnt_o == '0);
    ovf_evt_o  = wrap_evt_o || (adv_o && dual && !up_o && (cnt_o == ONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      up_o  <= 1'b1;
    end else begin
      if (load_i) begin
        cnt_o <= load_val_i;
      end else if (adv_o && single) begin
        cnt_o <= wrap_evt_o ? '0 : cnt_o + ONE;
      end else if (adv_o && dual) begin
        if (up_o) begin
          if (cnt_o >= top_i) begin
            up_o  <= 1'b0;
            cnt_o <= (cnt_o == '0) ? '0 : cnt_o - ONE;
          end else begin
            cnt_o <= cnt_o + ONE;
          end
        end else if (cnt_o == '0) begin
          up_o  <= 1'b1;
          cnt_o <= (top_i == '0) ? '0 : ONE;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end
      if (dir_rst_i) up_o <= 1'b1;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !load_i) |=> (cnt_o == $past(cnt_o)));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt_o |=> (cnt_o == '0));
  // R5
  climb_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_o && dual && up_o && (cnt_o < top_i)) |=> (cnt_o == $past(cnt_o) + ONE));
endmodule

// File: rtl/wt_chan.sv
module wt_chan
  import wtimer_pkg::*;
#(
  parameter int CW   = 16,
  parameter bit IS_A = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  fam_e          fam_i,
  input  logic          tog_ok_i,
  input  logic [1:0]    com_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          force_i,
  input  logic          adv_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          up_i,
  input  logic          wrap_evt_i,
  input  logic          top_evt_i,
  input  logic          bot_evt_i,
  input  logic          clr_i,
  output logic [CW-1:0] act_o,
  output logic          wave_o,
  output logic          flag_o
);
  logic [CW-1:0] buf_q;
  logic oc_q, oc_n, match, pwm, upd, tog_en, conn;

  always_comb begin
    pwm    = (fam_i == FAM_FAST) || (fam_i == FAM_PC) || (fam_i == FAM_PFC);
    upd    = ((fam_i == FAM_FAST) && wrap_evt_i) || ((fam_i == FAM_PC) && top_evt_i) ||
             ((fam_i == FAM_PFC) && bot_evt_i);
    match  = adv_i && (cnt_i == act_o);
    tog_en = IS_A && tog_ok_i;
    conn   = (com_i != 2'b00) && (fam_i != FAM_RSV) && !(pwm && (com_i == 2'b01) && !tog_en);
    oc_n   = oc_q;
    case (fam_i)
      FAM_NORM, FAM_CTC: begin
        if (force_i || match) begin
          case (com_i)
            2'b01:   oc_n = !oc_q;
            2'b10:   oc_n = 1'b0;
            2'b11:   oc_n = 1'b1;
            default: oc_n = oc_q;
          endcase
        end
      end
      FAM_FAST: begin
        if (com_i == 2'b01) begin
          if (tog_en && match) oc_n = !oc_q;
        end else if (com_i[1]) begin
          if (wrap_evt_i)  oc_n = !com_i[0];
          else if (match) oc_n = com_i[0];
        end
      end
      FAM_PC, FAM_PFC: begin
        if (com_i == 2'b01) begin
          if (tog_en && match) oc_n = !oc_q;
        end else if (com_i[1] && match) begin
          oc_n = up_i ? com_i[0] : !com_i[0];
        end
      end
      default: oc_n = oc_q;
    endcase
  end

  assign wave_o = oc_q && conn;

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q   <= 1'b0;
      flag_o <= 1'b0;
      buf_q  <= '0;
      act_o  <= '0;
    end else begin
      oc_q <= oc_n;
      if (match)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      if (upd) act_o <= buf_q;
      if (wr_i) begin
        buf_q <= wdata_i;
        if (!pwm) act_o <= wdata_i;
      end
    end
  end

  // R12
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(match));
  // R10
  force_pwm_chk: assert property (@(posedge clk) disable iff (rst)
    (pwm && force_i && !adv_i) |=> $stable(oc_q));
endmodule

// File: rtl/wave_timer.sv
module wave_timer
  import wtimer_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] count_o,
  output logic          wave_a_o,
  output logic          wave_b_o,
  output logic          flag_a_o,
  output logic          flag_b_o,
  output logic          flag_ovf_o
);
  localparam int NCH = 2;

  logic [7:0]    ctrl_q;
  logic [CW-1:0] topr_q, top_v, top_fix;
  mode_t         md;
  logic          load, dir_rst, up, adv, wrap_evt, top_evt, bot_evt, ovf_evt;
  logic [CW-1:0] act   [NCH];
  logic [NCH-1:0] wave, flag;

  always_comb begin
    md      = decode_mode(ctrl_q[3:0]);
    load    = wr_en && (wr_addr == AW'(A_CNT));
    dir_rst = wr_en && (wr_addr == AW'(A_CTRL));
    top_fix = (md.fixw == 2'd0) ? '1 : CW'((32'd1 << (32'(md.fixw) + 32'd7)) - 32'd1);
    case (md.tsel)
      TOPS_CMPA: top_v = act[0];
      TOPS_CAP:  top_v = topr_q;
      default:   top_v = top_fix;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      topr_q     <= '0;
      flag_ovf_o <= 1'b0;
    end else begin
      if (dir_rst) ctrl_q <= wr_data[7:0];
      if (wr_en && (wr_addr == AW'(A_TOPR))) topr_q <= wr_data;
      if (ovf_evt) flag_ovf_o <= 1'b1;
      else if (wr_en && (wr_addr == AW'(A_CLR)) && wr_data[2]) flag_ovf_o <= 1'b0;
    end
  end

  wt_counter #(.CW(CW)) i_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .fam_i(md.fam), .top_i(top_v),
    .load_i(load), .load_val_i(wr_data), .dir_rst_i(dir_rst),
    .cnt_o(count_o), .up_o(up), .adv_o(adv), .wrap_evt_o(wrap_evt),
    .top_evt_o(top_evt), .bot_evt_o(bot_evt), .ovf_evt_o(ovf_evt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    wt_chan #(.CW(CW), .IS_A(g == 0)) i_ch (
      .clk(clk), .rst(rst), .fam_i(md.fam), .tog_ok_i(md.tog_a),
      .com_i(ctrl_q[4+2*g +: 2]),
      .wr_i(wr_en && (wr_addr == AW'(32'(A_CMPA) + g))),
      .wdata_i(wr_data),
      .force_i(wr_en && (wr_addr == AW'(A_FORCE)) && wr_data[g]),
      .adv_i(adv), .cnt_i(count_o), .up_i(up),
      .wrap_evt_i(wrap_evt), .top_evt_i(top_evt), .bot_evt_i(bot_evt),
      .clr_i(wr_en && (wr_addr == AW'(A_CLR)) && wr_data[g]),
      .act_o(act[g]), .wave_o(wave[g]), .flag_o(flag[g])
    );
  end

  assign wave_a_o = wave[0];
  assign wave_b_o = wave[1];
  assign flag_a_o = flag[0];
  assign flag_b_o = flag[1];

  // R13
  rsv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((md.fam == FAM_RSV) && !load) |=> $stable(count_o));
  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && !dir_rst) |=> flag_ovf_o);
endmodule

// File: tb/test_wave_timer.sv
module test_wave_timer;
  localparam int CW = 16;
  localparam int AW = 3;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count_o;
  logic wave_a_o, wave_b_o, flag_a_o, flag_b_o, flag_ovf_o;

  always #5 clk = ~clk;

  wave_timer #(.CW(CW), .AW(AW)) i_wave_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .wave_a_o(wave_a_o), .wave_b_o(wave_b_o),
    .flag_a_o(flag_a_o), .flag_b_o(flag_b_o), .flag_ovf_o(flag_ovf_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit started = 0, tick_run = 0;
  int tick_div = 1, tick_ph = 0, maxc = 0;

  // tick generator
  always @(negedge clk) begin
    #1;
    tick_ph++;
    tick = tick_run && (tick_ph % tick_div == 0);
  end

  // ---------------- reference model ----------------
  int m_cnt, m_up, m_mode, m_com[2], m_buf[2], m_act[2], m_cap, m_oc[2], m_flag[2], m_ovf;
  int f, tp, com, ncnt, nup;
  bit ld, adv, single, dual, wrap, tturn, bturn, ovfe, match, frc, tog, upd;

  function automatic int fam_of(int m);
    if (m == 0) return 0;
    if (m == 4 || m == 12) return 1;
    if ((m >= 5 && m <= 7) || m == 14 || m == 15) return 2;
    if ((m >= 1 && m <= 3) || m == 10 || m == 11) return 3;
    if (m == 8 || m == 9) return 4;
    return 5;
  endfunction

  function automatic int top_of(int m, int a, int c);
    case (m)
      0: return 65535;
      1, 5: return 255;
      2, 6: return 511;
      3, 7: return 1023;
      4, 9, 11, 15: return a;
      8, 10, 12, 14: return c;
      default: return 0;
    endcase
  endfunction

  function automatic int wave_exp(int ch);
    int ff, cm;
    bit pwm, tg;
    ff = fam_of(m_mode);
    cm = m_com[ch];
    pwm = (ff >= 2 && ff <= 4);
    tg = (ch == 0) && (m_mode == 9 || m_mode == 11 || m_mode == 14 || m_mode == 15);
    if (cm == 0 || ff == 5 || (pwm && cm == 1 && !tg)) return 0;
    return m_oc[ch];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_mode = 0; m_cap = 0; m_ovf = 0;
      for (int c = 0; c < 2; c++) begin
        m_com[c] = 0; m_buf[c] = 0; m_act[c] = 0; m_oc[c] = 0; m_flag[c] = 0;
      end
    end else begin
      f = fam_of(m_mode);
      tp = top_of(m_mode, m_act[0], m_cap);
      ld = wr_en && wr_addr == 4;
      adv = tick && !ld && f != 5;
      single = f <= 2;
      dual = (f == 3 || f == 4);
      wrap = adv && single && (m_cnt == tp || m_cnt == 65535);
      tturn = adv && dual && m_up == 1 && m_cnt >= tp;
      bturn = adv && dual && m_up == 0 && m_cnt == 0;
      ovfe = wrap || (adv && dual && m_up == 0 && m_cnt == 1);
      for (int c = 0; c < 2; c++) begin
        com = m_com[c];
        match = adv && (m_cnt == m_act[c]);
        frc = wr_en && wr_addr == 5 && wr_data[c];
        tog = (c == 0) && (m_mode == 9 || m_mode == 11 || m_mode == 14 || m_mode == 15);
        if (f <= 1) begin
          if (frc || match) begin
            if (com == 1) m_oc[c] = 1 - m_oc[c];
            else if (com == 2) m_oc[c] = 0;
            else if (com == 3) m_oc[c] = 1;
          end
        end else if (f == 2) begin
          if (com == 1) begin
            if (tog && match) m_oc[c] = 1 - m_oc[c];
          end else if (com >= 2) begin
            if (wrap) m_oc[c] = (com == 2) ? 1 : 0;
            else if (match) m_oc[c] = (com == 2) ? 0 : 1;
          end
        end else if (dual) begin
          if (com == 1) begin
            if (tog && match) m_oc[c] = 1 - m_oc[c];
          end else if (com >= 2 && match) begin
            if (com == 2) m_oc[c] = m_up ? 0 : 1;
            else m_oc[c] = m_up ? 1 : 0;
          end
        end
        if (match) m_flag[c] = 1;
        else if (wr_en && wr_addr == 6 && wr_data[c]) m_flag[c] = 0;
        upd = (f == 2 && wrap) || (f == 3 && tturn) || (f == 4 && bturn);
        if (upd) m_act[c] = m_buf[c];
        if (wr_en && wr_addr == 1 + c) begin
          m_buf[c] = wr_data;
          if (f <= 1) m_act[c] = wr_data;
        end
      end
      if (ovfe) m_ovf = 1;
      else if (wr_en && wr_addr == 6 && wr_data[2]) m_ovf = 0;
      ncnt = m_cnt; nup = m_up;
      if (ld) ncnt = wr_data;
      else if (adv && single) ncnt = wrap ? 0 : m_cnt + 1;
      else if (adv && dual) begin
        if (m_up == 1) begin
          if (m_cnt >= tp) begin nup = 0; ncnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else ncnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          nup = 1; ncnt = (tp == 0) ? 0 : 1;
        end else ncnt = m_cnt - 1;
      end
      m_cnt = ncnt; m_up = nup;
      if (wr_en && wr_addr == 3) m_cap = wr_data;
      if (wr_en && wr_addr == 0) begin
        m_mode = wr_data[3:0]; m_com[0] = wr_data[5:4]; m_com[1] = wr_data[7:6]; m_up = 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(cur_req, "count", int'(count_o), m_cnt);
      chk(cur_req, "wave_a", int'(wave_a_o), wave_exp(0));
      chk(cur_req, "wave_b", int'(wave_b_o), wave_exp(1));
      chk(cur_req, "flag_a", int'(flag_a_o), m_flag[0]);
      chk(cur_req, "flag_b", int'(flag_b_o), m_flag[1]);
      chk(cur_req, "flag_ovf", int'(flag_ovf_o), m_ovf);
      if (int'(count_o) > maxc) maxc = int'(count_o);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #2;
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ctl(int mode, int ca, int cb);
    return mode | (ca << 4) | (cb << 6);
  endfunction

  int keep;

  initial begin
    run(3);
    #2 rst = 1'b0;
    @(negedge clk);
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "wave_a", int'(wave_a_o), 0);
    chk("R1", "wave_b", int'(wave_b_o), 0);
    chk("R1", "flags", int'({flag_a_o, flag_b_o, flag_ovf_o}), 0);
    started = 1;

    // R2 / R14: load with tick off, then slow ticks
    cur_req = "R2";
    wr(4, 5); run(4);
    chk("R14", "count after load", int'(count_o), 5);
    tick_div = 3; tick_run = 1; run(30);
    tick_div = 1;

    // R3: normal wrap, then clear-on-compare from TOP register
    cur_req = "R3";
    wr(4, 16'hFFF8); run(20);
    chk("R3", "ovf after wrap", int'(flag_ovf_o), 1);
    wr(6, 7);
    wr(3, 30); wr(0, ctl(12, 0, 0)); wr(4, 0); maxc = 0; run(100);
    chk("R3", "max count mode 12", maxc, 30);

    // R6: non-PWM output codes
    cur_req = "R6";
    wr(1, 25); wr(2, 10); wr(0, ctl(4, 1, 3)); run(120);
    chk("R6", "flag_a after matches", int'(flag_a_o), 1);
    wr(0, ctl(4, 2, 1)); run(120);
    wr(0, ctl(0, 3, 2)); wr(4, 0); run(60);

    // R12: clears, some colliding with matches
    cur_req = "R12";
    wr(0, ctl(4, 1, 1)); wr(4, 0);
    for (int i = 0; i < 40; i++) wr(6, 7);
    tick_run = 0; run(2);
    wr(6, 7); run(1);
    chk("R12", "flags cleared", int'({flag_a_o, flag_b_o, flag_ovf_o}), 0);

    // R10: force strobes
    cur_req = "R10";
    wr(1, 7); wr(0, ctl(4, 1, 2)); wr(4, 7);
    wr(5, 1); wr(5, 3); wr(5, 2); run(1);
    chk("R10", "count after force", int'(count_o), 7);
    chk("R10", "flags after force", int'({flag_a_o, flag_b_o}), 0);
    wr(0, ctl(5, 2, 3)); run(1);
    keep = int'({wave_a_o, wave_b_o});
    wr(5, 3); run(1);
    chk("R10", "pwm force ignored", int'({wave_a_o, wave_b_o}), keep);

    // R4: fixed TOPs
    cur_req = "R4";
    wr(1, 100); wr(2, 200); tick_run = 1;
    wr(4, 0); maxc = 0; run(600);
    chk("R4", "max count mode 5", maxc, 255);
    wr(0, ctl(7, 2, 3)); wr(4, 0); maxc = 0; run(2100);
    chk("R4", "max count mode 7", maxc, 1023);
    cur_req = "R5";
    wr(0, ctl(1, 2, 3)); wr(4, 0); maxc = 0; run(600);
    chk("R5", "max count mode 1", maxc, 255);

    // R7: fast PWM from TOP register, B matches at TOP
    cur_req = "R7";
    wr(3, 40); wr(1, 10); wr(2, 40); wr(0, ctl(14, 2, 3)); wr(4, 0); run(200);
    // R11: buffered compare with TOP = compare A
    cur_req = "R11";
    wr(1, 50); wr(2, 20); wr(0, ctl(15, 2, 2)); run(150);
    wr(1, 30); run(150);
    // R9: code 01 in PWM
    cur_req = "R9";
    wr(0, ctl(15, 1, 1)); run(150);
    wr(0, ctl(14, 1, 1)); run(100);
    wr(0, ctl(5, 1, 1)); run(50);
    chk("R9", "toggle disconnected mode 5", int'({wave_a_o, wave_b_o}), 0);

    // R8 / R5: dual slope
    cur_req = "R8";
    wr(3, 30); wr(1, 10); wr(2, 20); wr(0, ctl(10, 2, 3)); wr(4, 0); maxc = 0; run(200);
    chk("R5", "max count mode 10", maxc, 30);
    cur_req = "R11";
    wr(0, ctl(8, 3, 2)); run(100); wr(1, 5); run(100); wr(2, 25); run(100);
    cur_req = "R9";
    wr(1, 40); wr(2, 15); wr(0, ctl(11, 1, 1)); run(200);
    wr(0, ctl(9, 1, 2)); run(200);

    // R13: reserved mode
    cur_req = "R13";
    wr(0, ctl(13, 3, 3)); run(1);
    keep = int'(count_o);
    run(20);
    chk("R13", "count held", int'(count_o), keep);
    chk("R13", "pins low", int'({wave_a_o, wave_b_o}), 0);

    tick_run = 0; run(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule